// File: doc/BRIEF.md
# Infrared Carrier Modulator

This block produces the modulated line that drives an infrared transmitter. A divide-by-twelve counter runs on the main clock and yields a carrier whose high time is either one half or one third of its period. The carrier appears on the output only while both the enable bit and the output port bit are set. In every other case the line is held low.

The main clock is not a separate clock. It is a clock-enable pulse derived from the oscillator clock by a prescaler. The prescaler passes every oscillator cycle in the low-frequency setting and one cycle in eight in the high-frequency setting.

Control changes are taken only at a carrier period boundary, so a period already in progress always completes with its old settings. While the output is gated off, the counter rests at zero. Each burst therefore opens with a full high phase.

Top module: `ir_carrier_mod`

## Requirements
- R1: After reset the output is low and stays low while the enable and port bits are 0.
- R2: With the prescaler select at 0, one carrier period lasts exactly 12 oscillator clocks.
- R3: With duty select at 1, the output is high for 6 clocks and low for 6 clocks of each period.
- R4: With duty select at 0, the output is high for 4 clocks and low for 8 clocks of each period.
- R5: With the enable bit at 0, the output stays low whatever the other inputs are.
- R6: With the port bit at 0 at a period boundary, the output stays low.
- R7: With the prescaler select at 1, the main clock is the oscillator divided by 8. The high and low times are then 48/48 oscillator clocks (duty select 1) or 32/64 (duty select 0).
- R8: A change of duty select made during a period takes effect from the next period onward. The current period completes with the old duty.
- R9: When the enable bit is cleared during a period, that period completes with its full high phase, and the output is low from then on.
- R10: From idle, the output goes high on the first main-clock tick after the enable and port bits are both 1, and the first high phase has its full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_mode | input | 1 | Prescaler select, static: 1 divides the oscillator by 8, 0 passes it through |
| duty_half | input | 1 | Duty select: 1 gives a half duty, 0 gives a third duty |
| carrier_en | input | 1 | Carrier output enable |
| port_bit | input | 1 | Output port data bit; 0 holds the line low |
| ir_out | output | 1 | Modulated infrared line |

## Verification
The bench builds the block with its default parameters: a carrier divider of 12 and a prescaler of 8. It resets the block once with each prescaler setting. The pass-through setting makes the exact clock counts of both duties visible. The same counts, scaled by eight, expose any slip in the prescaler. The boundary timing of mid-period changes of duty and enable is also observable at single-clock resolution.

// File: rtl/ir_carrier_mod.sv
module ir_carrier_mod #(
  parameter int CAR_DIV = 12,
  parameter int PRE_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_mode,
  input  logic duty_half,
  input  logic carrier_en,
  input  logic port_bit,
  output logic ir_out
);
  localparam int CW = $clog2(CAR_DIV);
  localparam int PW = $clog2(PRE_DIV);
  localparam logic [CW-1:0] LAST   = CW'(CAR_DIV - 1);
  localparam logic [CW-1:0] T_HALF = CW'(CAR_DIV / 2);
  localparam logic [CW-1:0] T_3RD  = CW'(CAR_DIV / 3);
  localparam logic [PW-1:0] P_LAST = PW'(PRE_DIV - 1);

  logic [PW-1:0] pre_cnt;
  logic [CW-1:0] cnt;
  logic          act_on, act_half;
  logic          tick, boundary;
  logic [CW-1:0] thr;

  assign tick     = hs_mode ? (pre_cnt == P_LAST) : 1'b1;
  assign boundary = (cnt == LAST) || !act_on;
  assign thr      = act_half ? T_HALF : T_3RD;
  assign ir_out   = act_on && (cnt < thr);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      pre_cnt <= '0;
    else if (!hs_mode || pre_cnt == P_LAST)
      pre_cnt <= '0;
    else
      pre_cnt <= pre_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt      <= '0;
      act_on   <= 1'b0;
      act_half <= 1'b0;
    end else if (tick) begin
      if (boundary) begin
        cnt      <= '0;
        act_on   <= carrier_en && port_bit;
        act_half <= duty_half;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  p_hold_between_ticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt) && $stable(act_on) && $stable(act_half));

  p_tick_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_mode && $past(hs_mode) && tick) |=> !tick);

  p_ctrl_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && act_on && cnt != LAST) |=> $stable(act_half) && $stable(act_on));

  p_start_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_on) |-> $past(carrier_en) && $past(port_bit));

  p_burst_from_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_out) |-> cnt == '0);
endmodule

// File: tb/test_ir_carrier_mod.sv
module test_ir_carrier_mod;
  logic clk = 0, rst_n = 0;
  logic hs_mode = 0, duty_half = 0, carrier_en = 0, port_bit = 0;
  logic ir_out;
  int total = 0, bad = 0;
  int cyc = 0;
  bit done = 0;

  ir_carrier_mod i_ir_carrier_mod (
    .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .duty_half(duty_half),
    .carrier_en(carrier_en), .port_bit(port_bit), .ir_out(ir_out));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(logic hs);
    @(negedge clk);
    rst_n = 0; hs_mode = hs; duty_half = 0; carrier_en = 0; port_bit = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wait_rise();
    int n = 0;
    while (ir_out !== 1'b0 && n < 1000) begin @(negedge clk); n++; end
    while (ir_out !== 1'b1 && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic count_lvl(logic lvl, output int c);
    c = 0;
    while (ir_out === lvl && c < 500) begin @(negedge clk); c++; end
  endtask

  task automatic low_for(int n, output int highs);
    highs = 0;
    repeat (n) begin if (ir_out !== 1'b0) highs++; @(negedge clk); end
  endtask

  task automatic t_reset();
    int h;
    do_reset(0);
    chk("R1 out after reset", int'(ir_out), 0);
    duty_half = 1;
    low_for(40, h);
    chk("R1 idle highs", h, 0);
  endtask

  task automatic t_gating();
    int h;
    do_reset(0);
    duty_half = 1; carrier_en = 1; port_bit = 0;
    low_for(40, h);
    chk("R6 port low highs", h, 0);
    carrier_en = 0; port_bit = 1;
    low_for(40, h);
    chk("R5 enable low highs", h, 0);
  endtask

  task automatic t_burst_start();
    int hi;
    do_reset(0);
    duty_half = 1;
    carrier_en = 1; port_bit = 1;
    @(negedge clk);
    chk("R10 first tick high", int'(ir_out), 1);
    count_lvl(1, hi);
    chk("R10 first high length", hi, 6);
  endtask

  task automatic t_duty(logic d, int exp_hi, int exp_lo, string req);
    int hi, lo;
    do_reset(0);
    duty_half = d; carrier_en = 1; port_bit = 1;
    wait_rise();
    count_lvl(1, hi);
    count_lvl(0, lo);
    chk({req, " high"}, hi, exp_hi);
    chk({req, " low"}, lo, exp_lo);
    chk("R2 period", hi + lo, 12);
  endtask

  task automatic t_duty_change();
    int hi, lo, hi2;
    do_reset(0);
    duty_half = 1; carrier_en = 1; port_bit = 1;
    wait_rise();
    duty_half = 0;
    count_lvl(1, hi);
    count_lvl(0, lo);
    count_lvl(1, hi2);
    chk("R8 old period high", hi, 6);
    chk("R8 old period low", lo, 6);
    chk("R8 new period high", hi2, 4);
  endtask

  task automatic t_disable_mid();
    int hi, h;
    do_reset(0);
    duty_half = 1; carrier_en = 1; port_bit = 1;
    wait_rise();
    carrier_en = 0;
    count_lvl(1, hi);
    chk("R9 last high length", hi, 6);
    low_for(60, h);
    chk("R9 highs after disable", h, 0);
  endtask

  task automatic t_prescale();
    int hi, lo;
    do_reset(1);
    duty_half = 1; carrier_en = 1; port_bit = 1;
    wait_rise();
    count_lvl(1, hi);
    count_lvl(0, lo);
    chk("R7 half high", hi, 48);
    chk("R7 half low", lo, 48);
    duty_half = 0;
    wait_rise();
    wait_rise();
    count_lvl(1, hi);
    count_lvl(0, lo);
    chk("R7 third high", hi, 32);
    chk("R7 third low", lo, 64);
  endtask

  initial begin
    t_reset();
    t_gating();
    t_burst_start();
    t_duty(1, 6, 6, "R3");
    t_duty(0, 4, 8, "R4");
    t_duty_change();
    t_disable_mid();
    t_prescale();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule